// File: doc/BRIEF.md
# Flash Read-While-Busy Response Controller

This block stands between a bus read port and the sequencer of a flash array. A read that reaches it while the array is idle completes in the same cycle. A read that arrives while the array is programming or erasing is handled according to a 3-bit policy field. The read can be refused with a bus error. It can be held until the array becomes idle. It can also be held while the block asks the sequencer to abandon the running operation, so that the held read finishes sooner.

Two sticky interrupt flags report events to software. One marks the start of a stall. The other marks a completed abort. Each flag is raised only under the policy codes that enable it, and each is cleared by a write-one-to-clear strobe. The policy field is written through a simple strobe and data port, and reset loads the code that stalls without aborting or notifying. The bus master holds its read request high until it sees either `rd_ok` or `rd_err`.

Top module: `fbusy_rd_ctrl`

## Requirements
- R1: After reset the policy field holds 3'b111: all outputs are low, and a read that meets a busy array is stalled, with no abort request and no interrupt.
- R2: A read (rd_req high) while arr_busy is low gets rd_ok high in the same cycle, with rd_err low and no abort request, under every policy code.
- R3: When policy bit 2 is 0 (codes 3'b000 to 3'b011), a read that meets arr_busy high gets rd_err in the same cycle, never rd_ok, and causes no abort request and no interrupt.
- R4: When policy bit 2 is 1, a read that meets arr_busy high is stalled: rd_ok and rd_err stay low while arr_busy is high, and rd_ok rises in the first cycle in which arr_busy is low.
- R5: Under code 3'b110 the stall-notification flag irq_stall is set in the cycle after the stall begins. Codes 3'b111, 3'b101 and 3'b100 never set it.
- R6: Under codes 3'b101 and 3'b100, abort_req is a single-cycle pulse in the cycle after the stall begins, issued exactly once per stalled read. Other codes never pulse it.
- R7: Under code 3'b100, abort_done seen while an abort is outstanding sets irq_abort in the following cycle. Code 3'b101 never sets it.
- R8: Interrupt flags are sticky. irq_clr bit 0 clears irq_stall and bit 1 clears irq_abort, one cycle after the strobe. A flag whose clear bit is low keeps its value, and a set in the same cycle as a clear wins.
- R9: A policy write (pol_wr_en) takes effect in the following cycle. The code in force when a stall begins governs that read's abort and notification, even if the field is rewritten during the stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pol_wr_en | input | 1 | Policy field write strobe |
| pol_wr_data | input | 3 | New policy code |
| rd_req | input | 1 | Read request, held until rd_ok or rd_err |
| arr_busy | input | 1 | Array is programming or erasing |
| abort_done | input | 1 | Sequencer reports that the abort finished |
| irq_clr | input | 2 | Write-one-to-clear strobes: bit 0 stall, bit 1 abort |
| rd_ok | output | 1 | Read completes successfully this cycle |
| rd_err | output | 1 | Read terminates with an error this cycle |
| abort_req | output | 1 | One-cycle request to abandon the running operation |
| irq_stall | output | 1 | Sticky stall-notification flag |
| irq_abort | output | 1 | Sticky abort-notification flag |

## Verification
The assertions check on every cycle the properties that hold at all times: an error and a completion are never given together, no completion appears while a stalled read still sees a busy array, an idle-array read never waits, the abort request is a lone pulse issued only inside a stall, and a flag keeps or drops its value exactly as its clear bit dictates. Some behaviour only shows across a scenario, so only the bench's read sequences can show it. That covers the exact code-to-response mapping, the count of one abort per stalled read, the abort flag following abort_done under code 3'b100 only, and the code latched at stall start outliving a rewrite during the stall.

// File: rtl/fbrc_pkg.sv
package fbrc_pkg;

  localparam int POL_W = 3;
  localparam logic [POL_W-1:0] POL_RESET = 3'b111;
  localparam int IRQ_N = 2;
  localparam int IRQ_STALL = 0;
  localparam int IRQ_ABORT = 1;

  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_STALL = 1'b1
  } rd_state_e;

  // A set top bit means "hold the read"; a clear one means "refuse it".
  function automatic logic pol_stalls(input logic [POL_W-1:0] p);
    return p[POL_W-1];
  endfunction

  function automatic logic pol_stall_irq(input logic [POL_W-1:0] p);
    return p == 3'b110;
  endfunction

  function automatic logic pol_aborts(input logic [POL_W-1:0] p);
    return p[POL_W-1] && !p[1];
  endfunction

  function automatic logic pol_abort_irq(input logic [POL_W-1:0] p);
    return p == 3'b100;
  endfunction

endpackage

// File: rtl/fbrc_policy_reg.sv
module fbrc_policy_reg
  import fbrc_pkg::*;
#(
  parameter int W = POL_W,
  parameter logic [W-1:0] RST_VAL = POL_RESET
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] pol_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q <= RST_VAL;
    end else if (wr_en) begin
      pol_q <= wr_data;
    end
  end

  AST_POL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pol_q)); // R9
  AST_POL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> pol_q == $past(wr_data)); // R9

endmodule

// File: rtl/fbrc_resp_fsm.sv
module fbrc_resp_fsm
  import fbrc_pkg::*;
#(
  parameter int W = POL_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_req,
  input  logic         arr_busy,
  input  logic [W-1:0] pol_q,
  output logic         rd_ok,
  output logic         rd_err,
  output logic         stall_start,
  output logic         stall_active,
  output logic         stall_release
);

  rd_state_e st_q, st_d;
  logic busy_hit;

  assign busy_hit      = rd_req && arr_busy && (st_q == ST_IDLE);
  assign stall_start   = busy_hit && pol_stalls(pol_q);
  assign stall_active  = (st_q == ST_STALL);
  assign stall_release = stall_active && !arr_busy;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (stall_start)   st_d = ST_STALL;
      ST_STALL: if (stall_release) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign rd_ok  = rd_req && !arr_busy;
  assign rd_err = busy_hit && !pol_stalls(pol_q);

  AST_OK_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_ok && rd_err)); // R3
  AST_STALL_NO_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_active && arr_busy) |-> !rd_ok && !rd_err); // R4
  AST_RELEASE_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_release && rd_req) |-> rd_ok); // R4
  AST_IDLE_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_active && rd_req && !arr_busy) |-> rd_ok); // R2
  AST_STALL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    stall_start |=> stall_active); // R4

endmodule

// File: rtl/fbrc_abort_ctl.sv
module fbrc_abort_ctl
  import fbrc_pkg::*;
#(
  parameter int W = POL_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stall_start,
  input  logic         stall_active,
  input  logic         stall_release,
  input  logic [W-1:0] pol_q,
  input  logic         abort_done,
  output logic         abort_req,
  output logic         abort_irq_set
);

  logic req_q, pend_q, notify_q;
  logic start_abort;

  assign start_abort = stall_start && pol_aborts(pol_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q    <= 1'b0;
      pend_q   <= 1'b0;
      notify_q <= 1'b0;
    end else begin
      req_q <= start_abort;
      if (stall_start) notify_q <= pol_abort_irq(pol_q);
      if (start_abort)                        pend_q <= 1'b1;
      else if (abort_done || stall_release)   pend_q <= 1'b0;
    end
  end

  assign abort_req     = req_q;
  assign abort_irq_set = pend_q && abort_done && notify_q;

  AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> !abort_req); // R6
  AST_ABORT_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |-> stall_active); // R6
  AST_ABORT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |-> pend_q); // R7
  AST_NOTIFY_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    abort_irq_set |-> stall_active); // R7

endmodule

// File: rtl/fbrc_irq_flags.sv
module fbrc_irq_flags
  import fbrc_pkg::*;
#(
  parameter int N = IRQ_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flags[i] <= 1'b0;
      else if (set[i]) flags[i] <= 1'b1;
      else if (clr[i]) flags[i] <= 1'b0;
    end

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[i] && !clr[i]) |=> flags[i]); // R8
    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !set[i]) |=> !flags[i]); // R8
    AST_IRQ_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> flags[i]); // R8
  end

endmodule

// File: rtl/fbusy_rd_ctrl.sv
module fbusy_rd_ctrl
  import fbrc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pol_wr_en,
  input  logic [POL_W-1:0] pol_wr_data,
  input  logic             rd_req,
  input  logic             arr_busy,
  input  logic             abort_done,
  input  logic [IRQ_N-1:0] irq_clr,
  output logic             rd_ok,
  output logic             rd_err,
  output logic             abort_req,
  output logic             irq_stall,
  output logic             irq_abort
);

  logic [POL_W-1:0] pol_q;
  logic stall_start, stall_active, stall_release;
  logic stall_irq_set, abort_irq_set;
  logic [IRQ_N-1:0] irq_set, irq_q;

  fbrc_policy_reg #(.W(POL_W), .RST_VAL(POL_RESET)) u_pol (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (pol_wr_en),
    .wr_data (pol_wr_data),
    .pol_q   (pol_q)
  );

  fbrc_resp_fsm #(.W(POL_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_req        (rd_req),
    .arr_busy      (arr_busy),
    .pol_q         (pol_q),
    .rd_ok         (rd_ok),
    .rd_err        (rd_err),
    .stall_start   (stall_start),
    .stall_active  (stall_active),
    .stall_release (stall_release)
  );

  fbrc_abort_ctl #(.W(POL_W)) u_abort (
    .clk           (clk),
    .rst_n         (rst_n),
    .stall_start   (stall_start),
    .stall_active  (stall_active),
    .stall_release (stall_release),
    .pol_q         (pol_q),
    .abort_done    (abort_done),
    .abort_req     (abort_req),
    .abort_irq_set (abort_irq_set)
  );

  assign stall_irq_set = stall_start && pol_stall_irq(pol_q);

  always_comb begin
    irq_set            = '0;
    irq_set[IRQ_STALL] = stall_irq_set;
    irq_set[IRQ_ABORT] = abort_irq_set;
  end

  fbrc_irq_flags #(.N(IRQ_N)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (irq_set),
    .clr   (irq_clr),
    .flags (irq_q)
  );

  assign irq_stall = irq_q[IRQ_STALL];
  assign irq_abort = irq_q[IRQ_ABORT];

  AST_STALL_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_stall) |-> $past(stall_start)); // R5
  AST_ERR_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |=> !abort_req); // R3

endmodule

// File: tb/fbusy_rd_ctrl_bench.sv
module fbusy_rd_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pol_wr_en = 1'b0;
  logic [2:0] pol_wr_data = 3'b000;
  logic       rd_req = 1'b0;
  logic       arr_busy = 1'b0;
  logic       abort_done = 1'b0;
  logic [1:0] irq_clr = 2'b00;
  logic       rd_ok, rd_err, abort_req, irq_stall, irq_abort;

  int total = 0;
  int bad = 0;
  logic [2:0] cur_pol = 3'b111;
  logic exp_is = 1'b0;
  logic exp_ia = 1'b0;

  always #5 clk = ~clk;

  fbusy_rd_ctrl u_fbusy_rd_ctrl (
    .clk(clk), .rst_n(rst_n), .pol_wr_en(pol_wr_en), .pol_wr_data(pol_wr_data),
    .rd_req(rd_req), .arr_busy(arr_busy), .abort_done(abort_done), .irq_clr(irq_clr),
    .rd_ok(rd_ok), .rd_err(rd_err), .abort_req(abort_req),
    .irq_stall(irq_stall), .irq_abort(irq_abort)
  );

  // Expected behaviour per code, written from the requirement text.
  function automatic bit m_holds(input logic [2:0] p);
    return p >= 3'd4;
  endfunction
  function automatic bit m_stall_note(input logic [2:0] p);
    return p == 3'd6;
  endfunction
  function automatic bit m_kills(input logic [2:0] p);
    return p == 3'd4 || p == 3'd5;
  endfunction
  function automatic bit m_kill_note(input logic [2:0] p);
    return p == 3'd4;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic set_pol(input logic [2:0] p);
    @(negedge clk); pol_wr_en = 1'b1; pol_wr_data = p;
    @(negedge clk); pol_wr_en = 1'b0;
    cur_pol = p;
  endtask

  task automatic check_flags(input string req);
    #1;
    chk(irq_stall == exp_is, {req, " irq_stall"}, irq_stall, exp_is);
    chk(irq_abort == exp_ia, {req, " irq_abort"}, irq_abort, exp_ia);
  endtask

  task automatic clear_irq(input logic [1:0] m);
    @(negedge clk); irq_clr = m;
    @(negedge clk); irq_clr = 2'b00;
    if (m[0]) exp_is = 1'b0;
    if (m[1]) exp_ia = 1'b0;
    check_flags("R8");
  endtask

  task automatic idle_read();
    @(negedge clk); arr_busy = 1'b0; rd_req = 1'b1; #1;
    chk(rd_ok == 1'b1, "R2 rd_ok", rd_ok, 1);
    chk(rd_err == 1'b0, "R2 rd_err", rd_err, 0);
    @(negedge clk); rd_req = 1'b0; #1;
    chk(abort_req == 1'b0, "R2 abort_req", abort_req, 0);
  endtask

  task automatic busy_read(input int blen, input bit give_done, input bit mid_write);
    logic [2:0] p;
    int aborts;
    p = cur_pol;
    aborts = 0;
    @(negedge clk); arr_busy = 1'b1; rd_req = 1'b1; #1;
    if (!m_holds(p)) begin
      chk(rd_err == 1'b1, "R3 rd_err", rd_err, 1);
      chk(rd_ok == 1'b0, "R3 rd_ok", rd_ok, 0);
      @(negedge clk); rd_req = 1'b0; arr_busy = 1'b0; #1;
      chk(abort_req == 1'b0, "R3 abort_req", abort_req, 0);
      check_flags("R3");
      return;
    end
    chk(rd_ok == 1'b0 && rd_err == 1'b0, "R4 first cycle held", {rd_ok, rd_err}, 0);
    for (int c = 1; c <= blen; c++) begin
      @(negedge clk);
      pol_wr_en = mid_write && c == 1;
      pol_wr_data = 3'b111;
      abort_done = give_done && c == 2;
      #1;
      if (abort_req) aborts++;
      chk(rd_ok == 1'b0 && rd_err == 1'b0, "R4 held while busy", {rd_ok, rd_err}, 0);
      if (c == 1) begin
        if (m_stall_note(p)) exp_is = 1'b1;
        chk(irq_stall == exp_is, "R5 irq_stall", irq_stall, exp_is);
      end
      if (c == 3) begin
        if (give_done && m_kill_note(p)) exp_ia = 1'b1;
        chk(irq_abort == exp_ia, "R7 irq_abort (R9 latched code)", irq_abort, exp_ia);
      end
    end
    if (mid_write) cur_pol = 3'b111;
    @(negedge clk); arr_busy = 1'b0; #1;
    chk(rd_ok == 1'b1, "R4 release rd_ok", rd_ok, 1);
    chk(aborts == (m_kills(p) ? 1 : 0), "R6 abort pulses", aborts, m_kills(p) ? 1 : 0);
    @(negedge clk); rd_req = 1'b0;
    check_flags("R8 sticky");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    chk({rd_ok, rd_err, abort_req, irq_stall, irq_abort} == 5'b0, "R1 reset outputs",
        {rd_ok, rd_err, abort_req, irq_stall, irq_abort}, 0);
    @(negedge clk); rst_n = 1'b1;

    // R1: default code stalls without abort or flags.
    busy_read(4, 1'b1, 1'b0);
    chk(irq_stall == 1'b0 && irq_abort == 1'b0, "R1 no flags", {irq_stall, irq_abort}, 0);

    // R2 under every code, R3/R9: a freshly written refusing code applies at once.
    for (int k = 0; k < 8; k++) begin
      set_pol(3'(k));
      idle_read();
    end
    set_pol(3'b010);
    busy_read(3, 1'b0, 1'b0);

    // Directed notify codes, then W1C per bit (R8).
    set_pol(3'b110);
    busy_read(3, 1'b0, 1'b0);
    set_pol(3'b100);
    busy_read(5, 1'b1, 1'b0);
    clear_irq(2'b01);
    clear_irq(2'b10);
    set_pol(3'b101);
    busy_read(4, 1'b1, 1'b0);

    // R9: rewrite during an abort-notifying stall keeps the latched code.
    set_pol(3'b100);
    busy_read(4, 1'b1, 1'b1);
    clear_irq(2'b11);

    // Mixed random traffic.
    for (int n = 0; n < 80; n++) begin
      set_pol(3'($urandom_range(0, 7)));
      if ($urandom_range(0, 2) == 0) idle_read();
      busy_read(int'($urandom_range(3, 8)), 1'($urandom_range(0, 1)),
                $urandom_range(0, 5) == 0);
      if ($urandom_range(0, 1) == 1) clear_irq(2'($urandom_range(0, 3)));
    end

    summary();
    $finish;
  end

endmodule